// File: doc/BRIEF.md
# SPI ADC Channel Scan Sequencer

This block is an SPI master that brings up an external 8-channel, 10-bit serial converter and then scans its channels without stopping. After reset it sends a fixed wake-up word. It then writes the 12-bit configuration word from `cfg_word` and issues a read-back command. From then on it starts one conversion per channel in ascending order and wraps to channel 0 after the last channel.

The converter takes its conversion clock from SCLK, so the controller does not treat the end of a command frame as the end of the conversion. After every conversion command it keeps sending 16-clock frames with chip select high. It stops when it has seen the end-of-conversion line go low and then high again. The next selected frame carries the next command, and its reply holds the previous channel's result. The 10-bit value is taken from that reply and written into the channel's result register.

Each selected frame returns the reply to the command of the previous selected frame. Because of this, the configuration read-back arrives in the first conversion frame. A timeout counts dummy frames and abandons a conversion whose end-of-conversion handshake never completes.

Top module: `adc_scan_seq`

## Requirements
- R1: Every frame is 16 SCLK periods long. SCLK idles low. MOSI carries the word MSB first and changes only while SCLK is low. For a selected frame, chip select is low across all 16 clocks and does not change while SCLK is high.
- R2: After reset the first three selected frames are 0xA000, then {4'hA, cfg_word}, then 0x9000, in that order.
- R3: The low 12 bits of the reply to 0x9000 arrive in the next selected frame. They are compared with `cfg_word`. A mismatch sets `cfg_err`, which stays set until reset.
- R4: A conversion command is 16'h0000 with the channel number in bits [15:12]. Channels are started in the order 0, 1, ..., NUM_CH-1, and the scan then wraps back to 0.
- R5: After each conversion command the block sends 16-clock dummy frames with chip select high and MOSI low. It checks at the end of each dummy frame and stops once end-of-conversion has been seen low and is now high. With completion 14 clocks after a fall at the 16th command clock, this takes one dummy frame. With a fall at the 28th clock, it takes two.
- R6: The selected frame that follows completion returns the result left-justified. Bits [15:6] of that reply are stored in the result register of the channel converted before it.
- R7: When a result register is written, its `res_valid` bit pulses for exactly one cycle and at most one valid bit is high at a time. Its `res_updated` bit is set and stays set until reset.
- R8: If `timeout_frames` dummy frames pass without completion, `timeout_err` is set and stays set until reset. The next command is then issued, and the reply in that frame is discarded without writing any result register.
- R9: While reset is active, chip select is high, SCLK and MOSI are low, and all valid, updated and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 12 | Configuration settings written after the wake-up word |
| timeout_frames | input | TMO_W | Number of dummy frames allowed before a conversion is abandoned |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| eoc | input | 1 | End-of-conversion line from the converter, low while converting |
| res_data | output | NUM_CH*RES_W | Per-channel results, channel k in bits [k*RES_W +: RES_W] |
| res_valid | output | NUM_CH | One-cycle pulse per channel on result write |
| res_updated | output | NUM_CH | Sticky per-channel written flag |
| cfg_err | output | 1 | Sticky configuration read-back mismatch |
| timeout_err | output | 1 | Sticky end-of-conversion timeout |

## Verification
The bench runs the block against a converter model whose end-of-conversion timing is set by its configuration. Each run scans more than a full sweep of channels, and every channel's value differs between rounds. This shows whether a stored result is fresh, and whether it is filed under the right channel or under the command that fetched it.

Normal sampling and long sampling are told apart by the number of dummy clocks counted between commands. A converter that returns a stuck configuration bit shows that the read-back check fires while conversions carry on. A converter whose end-of-conversion line never moves shows that the timeout counts the programmed number of frames and stores nothing.

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq #(
  parameter int NUM_CH  = 8,
  parameter int RES_W   = 10,
  parameter int CLK_DIV = 2,
  parameter int TMO_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [11:0]             cfg_word,
  input  logic [TMO_W-1:0]        timeout_frames,
  output logic                    sclk,
  output logic                    cs_n,
  output logic                    mosi,
  input  logic                    miso,
  input  logic                    eoc,
  output logic [NUM_CH*RES_W-1:0] res_data,
  output logic [NUM_CH-1:0]       res_valid,
  output logic [NUM_CH-1:0]       res_updated,
  output logic                    cfg_err,
  output logic                    timeout_err
);
  localparam int CHW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [15:0] WAKE_CMD = 16'hA000;
  localparam logic [15:0] RDBK_CMD = 16'h9000;

  typedef enum logic [2:0] {S_WAKE, S_CFG, S_RDBK, S_CONV, S_WAIT} state_t;
  typedef enum logic [1:0] {P_NONE, P_CFG, P_CONV} pend_t;

  state_t state_q;
  pend_t pend_q;
  logic [CHW-1:0] ch_q, prev_ch_q;
  logic [TMO_W-1:0] dum_q;
  logic seen_low_q, issued_q;
  logic eoc_m_q, eoc_s_q;
  logic [RES_W-1:0] res_q [NUM_CH];

  logic busy_q, sel_q, done_q, sclk_q;
  logic [DIVW-1:0] div_q;
  logic [3:0] bit_q;
  logic [15:0] tx_q, rx_q;

  logic start, start_sel, tick;
  logic [15:0] start_word;

  assign start     = !busy_q && !issued_q;
  assign start_sel = (state_q != S_WAIT);
  assign tick      = busy_q && (div_q == DIVW'(CLK_DIV - 1));
  assign sclk      = sclk_q;
  assign cs_n      = !(busy_q && sel_q);
  assign mosi      = busy_q && tx_q[15];

  always_comb begin
    case (state_q)
      S_WAKE:  start_word = WAKE_CMD;
      S_CFG:   start_word = {4'hA, cfg_word};
      S_RDBK:  start_word = RDBK_CMD;
      S_CONV:  start_word = 16'(ch_q) << 12;
      default: start_word = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sel_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0;
      div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1; sel_q <= start_sel; tx_q <= start_word;
        bit_q <= '0; div_q <= '0; sclk_q <= 1'b0;
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q <= {rx_q[14:0], miso};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 4'd15) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 4'd1;
              tx_q <= {tx_q[14:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DIVW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_m_q <= 1'b1;
      eoc_s_q <= 1'b1;
    end else begin
      eoc_m_q <= eoc;
      eoc_s_q <= eoc_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_WAKE; pend_q <= P_NONE; ch_q <= '0; prev_ch_q <= '0;
      dum_q <= '0; seen_low_q <= 1'b0; issued_q <= 1'b0;
      cfg_err <= 1'b0; timeout_err <= 1'b0;
      res_valid <= '0; res_updated <= '0;
      for (int k = 0; k < NUM_CH; k++) res_q[k] <= '0;
    end else begin
      res_valid <= '0;
      if (start) issued_q <= 1'b1;
      if (state_q == S_WAIT && !eoc_s_q) seen_low_q <= 1'b1;
      if (done_q) begin
        issued_q <= 1'b0;
        case (state_q)
          S_WAKE: state_q <= S_CFG;
          S_CFG:  state_q <= S_RDBK;
          S_RDBK: begin
            pend_q <= P_CFG;
            state_q <= S_CONV;
          end
          S_CONV: begin
            if (pend_q == P_CFG && rx_q[11:0] != cfg_word) cfg_err <= 1'b1;
            if (pend_q == P_CONV) begin
              res_q[prev_ch_q] <= rx_q[15:16-RES_W];
              res_valid[prev_ch_q] <= 1'b1;
              res_updated[prev_ch_q] <= 1'b1;
            end
            pend_q <= P_CONV;
            prev_ch_q <= ch_q;
            ch_q <= (ch_q == CHW'(NUM_CH - 1)) ? '0 : ch_q + CHW'(1);
            dum_q <= '0;
            seen_low_q <= 1'b0;
            state_q <= S_WAIT;
          end
          default: begin
            if (seen_low_q && eoc_s_q) begin
              state_q <= S_CONV;
            end else if ((TMO_W+1)'(dum_q) + 1 >= (TMO_W+1)'(timeout_frames)) begin
              timeout_err <= 1'b1;
              pend_q <= P_NONE;
              state_q <= S_CONV;
            end else begin
              dum_q <= dum_q + TMO_W'(1);
            end
          end
        endcase
      end
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_res
    assign res_data[k*RES_W +: RES_W] = res_q[k];
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              cs_n,
  input logic              mosi,
  input logic [NUM_CH-1:0] res_valid,
  input logic [NUM_CH-1:0] res_updated,
  input logic              cfg_err,
  input logic              timeout_err
);
  assert_cs_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(cs_n));
  assert_mosi_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  assert_cfg_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_valid));
  assert_valid_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid & res_updated) == res_valid);
  assert_updated_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((res_updated & $past(res_updated)) == $past(res_updated)));
  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH)) i_chk (.*);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
  localparam int NCH = 8;
  localparam int RW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2.5 clk = ~clk;

  logic [11:0] cfg_word = 12'h004;
  logic [7:0] timeout_frames = 8'd4;
  logic sclk, cs_n, mosi, miso;
  logic eoc = 1'b1;
  logic [NCH*RW-1:0] res_data;
  logic [NCH-1:0] res_valid, res_updated;
  logic cfg_err, timeout_err;

  int errors = 0;
  int checks = 0;

  adc_scan_seq #(.NUM_CH(NCH), .RES_W(RW), .CLK_DIV(2), .TMO_W(8)) i_adc_scan_seq (.*);

  function automatic int val_of(int ch, int n);
    return (ch * 131 + n * 57 + 3) % 1024;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [11:0] stuck_mask = '0;
  bit eoc_dead = 0;
  logic [3:0] bc;
  logic [15:0] rxw, reply, w;
  logic [11:0] mcfg;
  bit mlong, conv_on;
  int edges, conv_ch, dummy_edges, dummy_last, mosi_bad, frame_bad, log_n;
  int done_cnt [NCH];
  logic [15:0] cmd_log [64];

  assign miso = !cs_n ? reply[4'd15 - bc] : 1'b0;

  always @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      bc = 0; rxw = 0; reply = 0; mcfg = 0; mlong = 0; conv_on = 0;
      edges = 0; conv_ch = 0; dummy_edges = 0; dummy_last = 0; mosi_bad = 0; log_n = 0;
      eoc = 1'b1;
      for (int k = 0; k < NCH; k++) done_cnt[k] = 0;
    end else begin
      if (conv_on) begin
        edges++;
        if (!eoc_dead && edges == (mlong ? 28 : 16)) eoc = 1'b0;
        if (!eoc_dead && edges == (mlong ? 42 : 30)) begin
          eoc = 1'b1;
          conv_on = 0;
          reply = 16'(val_of(conv_ch, done_cnt[conv_ch])) << 6;
          done_cnt[conv_ch]++;
        end
      end
      if (cs_n) begin
        dummy_edges++;
        if (mosi) mosi_bad++;
      end else begin
        w = {rxw[14:0], mosi};
        rxw = w;
        if (bc == 4'd15) begin
          bc = 0;
          if (log_n < 64) cmd_log[log_n] = w;
          log_n++;
          if (w[15:12] == 4'hA) begin
            mcfg = w[11:0];
            mlong = w[9];
            reply = 0;
          end else if (w == 16'h9000) begin
            reply = {4'h0, mcfg | stuck_mask};
          end else if (w[15] == 1'b0) begin
            conv_on = 1;
            conv_ch = int'(w[14:12]);
            edges = 16;
            reply = 0;
            dummy_last = dummy_edges;
            dummy_edges = 0;
            if (!mlong && !eoc_dead) eoc = 1'b0;
          end
        end else begin
          bc = bc + 4'd1;
        end
      end
    end
  end

  always @(posedge cs_n) if (rst_n && bc != 0) frame_bad++;

  logic [NCH-1:0] prev_valid = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        if (res_valid[k]) begin
          chk(res_data[k*RW +: RW] == RW'(val_of(k, done_cnt[k] - 1)), "R6 result value",
              int'(res_data[k*RW +: RW]), val_of(k, done_cnt[k] - 1));
        end
      end
      if (res_valid != 0) chk(prev_valid == 0, "R7 one-cycle valid pulse", int'(prev_valid), 0);
      prev_valid = res_valid;
    end else begin
      prev_valid = '0;
    end
  end

  task automatic run(input logic [11:0] cfg, input logic [11:0] stuck, input bit dead,
                     input int tmo, input int nconv, input int exp_dummy,
                     input bit exp_cfg_err, input string tag);
    int cyc;
    rst_n = 1'b0;
    cfg_word = cfg; timeout_frames = 8'(tmo); stuck_mask = stuck; eoc_dead = dead;
    frame_bad = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R9 reset pins", {cs_n, sclk, mosi}, 3'b100);
    chk(res_valid === '0 && res_updated === '0 && cfg_err === 1'b0 && timeout_err === 1'b0,
        "R9 reset flags", int'({res_valid, res_updated, cfg_err, timeout_err}), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (log_n < 3 + nconv && cyc < 30000) begin
      @(posedge clk);
      cyc++;
    end
    chk(cyc < 30000, "watchdog", cyc, 30000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    $display("run %s", tag);
    chk(cmd_log[0] == 16'hA000, "R2 wake word", int'(cmd_log[0]), 16'hA000);
    chk(cmd_log[1] == {4'hA, cfg}, "R2 config write", int'(cmd_log[1]), int'({4'hA, cfg}));
    chk(cmd_log[2] == 16'h9000, "R2 read-back command", int'(cmd_log[2]), 16'h9000);
    for (int k = 0; k < nconv; k++) begin
      chk(cmd_log[3 + k] == (16'(k % NCH) << 12), "R4 channel order and wrap",
          int'(cmd_log[3 + k]), int'(16'(k % NCH) << 12));
    end
    chk(dummy_last == exp_dummy, "R5 dummy clocks between commands", dummy_last, exp_dummy);
    chk(mosi_bad == 0, "R5 MOSI low in dummy frames", mosi_bad, 0);
    chk(frame_bad == 0, "R1 16-clock frames", frame_bad, 0);
    chk(cfg_err == exp_cfg_err, "R3 read-back mismatch flag", int'(cfg_err), int'(exp_cfg_err));
    chk(timeout_err == dead, "R8 timeout flag", int'(timeout_err), int'(dead));
    if (dead) chk(res_updated == '0, "R8 discarded replies", int'(res_updated), 0);
    else      chk(res_updated == '1, "R7 updated flags", int'(res_updated), 8'hFF);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    run(12'h004, 12'h000, 0, 4, 12, 16, 0, "normal sampling");
    run(12'h004, 12'h080, 0, 4, 10, 16, 1, "stuck read-back bit");
    run(12'h204, 12'h000, 0, 4, 11, 32, 0, "long sampling");
    run(12'h004, 12'h000, 1, 3, 5, 48, 0, "dead end-of-conversion");
    run(12'h0F0, 12'h000, 0, 2, 17, 16, 0, "second config, two sweeps");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule